// File: doc/BRIEF.md
# Two-Slot Static Issue Gate

This block is the issue stage of a two-wide, statically scheduled pipeline. Each cycle it may receive a 64-bit fetch bundle: two instruction words in fixed positions, each with pre-decoded fields (class, destination register, two source registers) and the bundle's fetch address. The lower slot feeds the ALU/branch pipe and the upper slot feeds the load/store pipe. Both pipes then advance in lockstep.

The gate checks each bundle before releasing it. A bundle whose address is not 8-byte aligned, or whose slots hold instructions of the wrong class, is dropped and flagged. Two timing hazards cannot be covered by forwarding. The first is a load/store slot that reads the result of the ALU slot of the same bundle. The gate splits such a bundle over two cycles, ALU half first. The second is any instruction that reads the destination of a load issued in the previous cycle. The gate holds such a bundle for one bubble cycle. While it holds a bundle, it keeps the take strobe low, so the fetch side presents the same bundle again.

Top module: `pair_issue_unit`

## Requirements
- R1: During and right after reset, both pipe outputs carry a bubble and the error flag is low. A bubble is class 0, all three register fields 31, the word equal to the NOP_WORD parameter and the address 0.
- R2: A legal bundle with no hazard is consumed in the cycle it is presented (take high). On the next clock edge, the lower slot appears on the ALU pipe with the bundle address, and the upper slot appears on the memory pipe with the bundle address plus 4. Class encodings are: 0 no-op, 1 ALU, 2 branch, 3 load, 4 store.
- R3: The lower slot must hold class 0, 1 or 2, and the upper slot must hold class 0, 3 or 4. Any other value, including 5 to 7, makes the bundle consumed with bubbles on both pipes and the error flag high for that one output cycle.
- R4: A bundle whose address has any of its three low bits set is handled as in R3.
- R5: If the lower slot is an ALU op writing register r (r not 31), and the upper slot reads r, the bundle is split. In the first cycle the ALU pipe issues the lower slot, the memory pipe gets a bubble, and take is low. In the next cycle the ALU pipe gets a bubble, the memory pipe issues the upper slot, and take is high. Every class reads source 1. Only ALU, branch and store read source 2.
- R6: If the memory pipe output currently holds a load with destination r, then a presented bundle in which either slot reads r gets bubbles on both pipes, with take low. It issues normally one cycle later.
- R7: Register 31 never causes a split or a load-use stall.
- R8: Fields a class does not use never cause a hazard. These are a load's source 2, and the destination field of branch, store and no-op.
- R9: With no valid bundle, take stays low and both pipes receive bubbles.
- R10: An address or class error takes priority over any load-use stall: the bundle is consumed and flagged without a stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd_valid | input | 1 | Fetch bundle present |
| bnd_addr | input | ADDR_W | Address of the lower slot |
| lo_cls | input | 3 | Lower slot class |
| lo_rd | input | 5 | Lower slot destination |
| lo_rs1 | input | 5 | Lower slot source 1 |
| lo_rs2 | input | 5 | Lower slot source 2 |
| lo_word | input | 32 | Lower slot instruction word |
| hi_cls | input | 3 | Upper slot class |
| hi_rd | input | 5 | Upper slot destination |
| hi_rs1 | input | 5 | Upper slot source 1 |
| hi_rs2 | input | 5 | Upper slot source 2 |
| hi_word | input | 32 | Upper slot instruction word |
| bnd_take | output | 1 | Bundle consumed this cycle |
| ap_cls | output | 3 | ALU pipe class |
| ap_rd | output | 5 | ALU pipe destination |
| ap_rs1 | output | 5 | ALU pipe source 1 |
| ap_rs2 | output | 5 | ALU pipe source 2 |
| ap_word | output | 32 | ALU pipe instruction word |
| ap_pc | output | ADDR_W | ALU pipe instruction address |
| mp_cls | output | 3 | Memory pipe class |
| mp_rd | output | 5 | Memory pipe destination |
| mp_rs1 | output | 5 | Memory pipe source 1 |
| mp_rs2 | output | 5 | Memory pipe source 2 |
| mp_word | output | 32 | Memory pipe instruction word |
| mp_pc | output | ADDR_W | Memory pipe instruction address |
| pkt_err | output | 1 | Bundle dropped as malformed |

## Verification
The assertions check four things on every cycle. The two pipes never carry a same-cycle ALU-to-memory register dependence. Nothing issued right after a load reads that load's destination. Each pipe only ever carries classes legal for its slot. An error cycle and an idle cycle both leave bubbles behind. Other behaviour can only be shown by the bench's scenarios: the exact cycle in which take rises, how a split or a stall spreads one bundle over two cycles, the addresses attached to each half, and the fact that register 31 and unused fields cause no extra delay.

// File: rtl/pair_pkg.sv
package pair_pkg;

    localparam int REG_W  = 5;
    localparam int WORD_W = 32;
    localparam logic [REG_W-1:0] ZERO_REG = '1;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ALU = 3'd1,
        OP_BR  = 3'd2,
        OP_LD  = 3'd3,
        OP_ST  = 3'd4
    } op_cls_e;

    typedef enum logic {
        PH_FULL,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        op_cls_e           cls;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  rs1;
        logic [REG_W-1:0]  rs2;
        logic [WORD_W-1:0] word;
    } slot_t;

    function automatic logic uses_src1(op_cls_e c);
        return c inside {OP_ALU, OP_BR, OP_LD, OP_ST};
    endfunction

    function automatic logic uses_src2(op_cls_e c);
        return c inside {OP_ALU, OP_BR, OP_ST};
    endfunction

    // true when an instruction of class c with these sources reads register r
    function automatic logic src_reads(op_cls_e c, logic [REG_W-1:0] s1,
                                       logic [REG_W-1:0] s2, logic [REG_W-1:0] r);
        return (r != ZERO_REG) &&
               ((uses_src1(c) && s1 == r) || (uses_src2(c) && s2 == r));
    endfunction

    function automatic logic cls_legal(int unsigned slot, op_cls_e c);
        if (slot == 0) return c inside {OP_NOP, OP_ALU, OP_BR};
        else           return c inside {OP_NOP, OP_LD, OP_ST};
    endfunction

endpackage

// File: rtl/pair_hazard.sv
module pair_hazard
    import pair_pkg::*;
#(
    parameter int ALIGN_BITS = 3
) (
    input  logic [ALIGN_BITS-1:0] addr_lo,
    input  op_cls_e               cls0,
    input  op_cls_e               cls1,
    input  logic [REG_W-1:0]      dst0,
    input  logic [1:0][REG_W-1:0] src0,
    input  logic [1:0][REG_W-1:0] src1,
    input  logic                  ld_vld,
    input  logic [REG_W-1:0]      ld_dst,
    output logic                  err,
    output logic                  ld_stall,
    output logic                  split
);
    localparam int NSLOT = 2;

    op_cls_e                  cls_a [NSLOT];
    logic [1:0][REG_W-1:0]    src_a [NSLOT];
    logic [NSLOT-1:0]         slot_ok;
    logic [NSLOT-1:0]         ld_hit;

    assign cls_a[0] = cls0;
    assign cls_a[1] = cls1;
    assign src_a[0] = src0;
    assign src_a[1] = src1;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        assign slot_ok[i] = cls_legal(i, cls_a[i]);
        assign ld_hit[i]  = src_reads(cls_a[i], src_a[i][0], src_a[i][1], ld_dst);
    end

    assign err      = (|addr_lo) || !(&slot_ok);
    assign ld_stall = ld_vld && (|ld_hit);
    assign split    = (cls0 == OP_ALU) && (dst0 != ZERO_REG) &&
                      src_reads(cls1, src1[0], src1[1], dst0);

endmodule

// File: rtl/pair_issue_seq.sv
module pair_issue_seq
    import pair_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  slot_t             s0,
    input  slot_t             s1,
    input  logic              err,
    input  logic              ld_stall,
    input  logic              split,
    output logic              take,
    output slot_t             alu_q,
    output slot_t             mem_q,
    output logic [ADDR_W-1:0] apc_q,
    output logic [ADDR_W-1:0] mpc_q,
    output logic              err_q
);
    localparam slot_t NOP_SLOT = '{cls: OP_NOP, rd: ZERO_REG, rs1: ZERO_REG,
                                   rs2: ZERO_REG, word: NOP_WORD};
    localparam logic [ADDR_W-1:0] SLOT_STEP = ADDR_W'(4);

    phase_e            ph_q, ph_n;
    slot_t             alu_n, mem_n;
    logic [ADDR_W-1:0] apc_n, mpc_n;
    logic              err_n;

    always_comb begin
        alu_n = NOP_SLOT;
        mem_n = NOP_SLOT;
        apc_n = '0;
        mpc_n = '0;
        err_n = 1'b0;
        take  = 1'b0;
        ph_n  = ph_q;
        if (valid) begin
            if (ph_q == PH_TAIL) begin
                mem_n = s1;
                mpc_n = addr + SLOT_STEP;
                take  = 1'b1;
                ph_n  = PH_FULL;
            end else if (err) begin
                err_n = 1'b1;
                take  = 1'b1;
            end else if (ld_stall) begin
                take  = 1'b0;
            end else if (split) begin
                alu_n = s0;
                apc_n = addr;
                ph_n  = PH_TAIL;
            end else begin
                alu_n = s0;
                mem_n = s1;
                apc_n = addr;
                mpc_n = addr + SLOT_STEP;
                take  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_FULL;
            alu_q <= NOP_SLOT;
            mem_q <= NOP_SLOT;
            apc_q <= '0;
            mpc_q <= '0;
            err_q <= 1'b0;
        end else begin
            ph_q  <= ph_n;
            alu_q <= alu_n;
            mem_q <= mem_n;
            apc_q <= apc_n;
            mpc_q <= mpc_n;
            err_q <= err_n;
        end
    end

    // R5
    no_rawpair_chk: assert property (@(posedge clk) disable iff (rst)
        !((alu_q.cls == OP_ALU) &&
          src_reads(mem_q.cls, mem_q.rs1, mem_q.rs2, alu_q.rd)));

    // R6
    no_loaduse_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_q.cls == OP_LD) |=>
        !(src_reads(alu_q.cls, alu_q.rs1, alu_q.rs2, $past(mem_q.rd)) ||
          src_reads(mem_q.cls, mem_q.rs1, mem_q.rs2, $past(mem_q.rd))));

    // R2
    slot_order_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_q.cls inside {OP_NOP, OP_ALU, OP_BR}) &&
        (mem_q.cls inside {OP_NOP, OP_LD, OP_ST}));

    // R3
    err_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (alu_q.cls == OP_NOP) && (mem_q.cls == OP_NOP));

    // R9
    idle_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |=> (alu_q.cls == OP_NOP) && (mem_q.cls == OP_NOP) && !err_q);

endmodule

// File: rtl/pair_issue_unit.sv
module pair_issue_unit
    import pair_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                ALIGN_BITS = 3,
    parameter logic [WORD_W-1:0] NOP_WORD   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bnd_valid,
    input  logic [ADDR_W-1:0] bnd_addr,
    input  logic [2:0]        lo_cls,
    input  logic [REG_W-1:0]  lo_rd,
    input  logic [REG_W-1:0]  lo_rs1,
    input  logic [REG_W-1:0]  lo_rs2,
    input  logic [WORD_W-1:0] lo_word,
    input  logic [2:0]        hi_cls,
    input  logic [REG_W-1:0]  hi_rd,
    input  logic [REG_W-1:0]  hi_rs1,
    input  logic [REG_W-1:0]  hi_rs2,
    input  logic [WORD_W-1:0] hi_word,
    output logic              bnd_take,
    output logic [2:0]        ap_cls,
    output logic [REG_W-1:0]  ap_rd,
    output logic [REG_W-1:0]  ap_rs1,
    output logic [REG_W-1:0]  ap_rs2,
    output logic [WORD_W-1:0] ap_word,
    output logic [ADDR_W-1:0] ap_pc,
    output logic [2:0]        mp_cls,
    output logic [REG_W-1:0]  mp_rd,
    output logic [REG_W-1:0]  mp_rs1,
    output logic [REG_W-1:0]  mp_rs2,
    output logic [WORD_W-1:0] mp_word,
    output logic [ADDR_W-1:0] mp_pc,
    output logic              pkt_err
);
    slot_t s0, s1, alu_q, mem_q;
    logic  err, ld_stall, split;

    assign s0 = '{cls: op_cls_e'(lo_cls), rd: lo_rd, rs1: lo_rs1, rs2: lo_rs2, word: lo_word};
    assign s1 = '{cls: op_cls_e'(hi_cls), rd: hi_rd, rs1: hi_rs1, rs2: hi_rs2, word: hi_word};

    pair_hazard #(.ALIGN_BITS(ALIGN_BITS)) u_haz (
        .addr_lo  (bnd_addr[ALIGN_BITS-1:0]),
        .cls0     (s0.cls),
        .cls1     (s1.cls),
        .dst0     (s0.rd),
        .src0     ({s0.rs2, s0.rs1}),
        .src1     ({s1.rs2, s1.rs1}),
        .ld_vld   (mem_q.cls == OP_LD),
        .ld_dst   (mem_q.rd),
        .err      (err),
        .ld_stall (ld_stall),
        .split    (split)
    );

    pair_issue_seq #(.ADDR_W(ADDR_W), .NOP_WORD(NOP_WORD)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .valid    (bnd_valid),
        .addr     (bnd_addr),
        .s0       (s0),
        .s1       (s1),
        .err      (err),
        .ld_stall (ld_stall),
        .split    (split),
        .take     (bnd_take),
        .alu_q    (alu_q),
        .mem_q    (mem_q),
        .apc_q    (ap_pc),
        .mpc_q    (mp_pc),
        .err_q    (pkt_err)
    );

    assign ap_cls  = alu_q.cls;
    assign ap_rd   = alu_q.rd;
    assign ap_rs1  = alu_q.rs1;
    assign ap_rs2  = alu_q.rs2;
    assign ap_word = alu_q.word;
    assign mp_cls  = mem_q.cls;
    assign mp_rd   = mem_q.rd;
    assign mp_rs1  = mem_q.rs1;
    assign mp_rs2  = mem_q.rs2;
    assign mp_word = mem_q.word;

endmodule

// File: tb/sim_pair_issue_unit.sv
module sim_pair_issue_unit;
    import pair_pkg::*;

    localparam int AW = 32;

    typedef struct {
        slot_t         ap;
        slot_t         mp;
        logic [AW-1:0] apc;
        logic [AW-1:0] mpc;
        logic          err;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bv = 1'b0;
    logic [AW-1:0] ba = '0;
    slot_t b0, b1;
    logic take, perr;
    logic [2:0] apc_c, mpc_c;
    logic [REG_W-1:0] ard, ars1, ars2, mrd, mrs1, mrs2;
    logic [31:0] aw, mw;
    logic [AW-1:0] apc, mpc;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    pair_issue_unit u0 (
        .clk(clk), .rst(rst), .bnd_valid(bv), .bnd_addr(ba),
        .lo_cls(b0.cls), .lo_rd(b0.rd), .lo_rs1(b0.rs1), .lo_rs2(b0.rs2), .lo_word(b0.word),
        .hi_cls(b1.cls), .hi_rd(b1.rd), .hi_rs1(b1.rs1), .hi_rs2(b1.rs2), .hi_word(b1.word),
        .bnd_take(take),
        .ap_cls(apc_c), .ap_rd(ard), .ap_rs1(ars1), .ap_rs2(ars2), .ap_word(aw), .ap_pc(apc),
        .mp_cls(mpc_c), .mp_rd(mrd), .mp_rs1(mrs1), .mp_rs2(mrs2), .mp_word(mw), .mp_pc(mpc),
        .pkt_err(perr)
    );

    function automatic slot_t mk(op_cls_e c, int rd, int r1, int r2, logic [31:0] w);
        return '{cls: c, rd: REG_W'(rd), rs1: REG_W'(r1), rs2: REG_W'(r2), word: w};
    endfunction

    slot_t BUB;
    initial BUB = mk(OP_NOP, 31, 31, 31, 32'h0);

    function automatic slot_t got_ap();
        return '{cls: op_cls_e'(apc_c), rd: ard, rs1: ars1, rs2: ars2, word: aw};
    endfunction
    function automatic slot_t got_mp();
        return '{cls: op_cls_e'(mpc_c), rd: mrd, rs1: mrs1, rs2: mrs2, word: mw};
    endfunction

    task automatic check_outs(exp_t e);
        checks++;
        if (got_ap() !== e.ap || got_mp() !== e.mp || apc !== e.apc ||
            mpc !== e.mpc || perr !== e.err) begin
            errors++;
            $display("FAIL %s: ap=%h/%h mp=%h/%h err=%b expected ap=%h/%h mp=%h/%h err=%b",
                     e.tag, got_ap(), apc, got_mp(), mpc, perr,
                     e.ap, e.apc, e.mp, e.mpc, e.err);
        end
    endtask

    // driver: one call per cycle; checks take now, queues the outputs due after the edge
    task automatic step(input logic v, input logic [AW-1:0] a, input slot_t x0, input slot_t x1,
                        input logic e_take, input slot_t e_ap, input logic [AW-1:0] e_apc,
                        input slot_t e_mp, input logic [AW-1:0] e_mpc, input logic e_err,
                        input string tag);
        exp_t e;
        @(negedge clk);
        bv = v; ba = a; b0 = x0; b1 = x1;
        #1;
        checks++;
        if (take !== e_take) begin
            errors++;
            $display("FAIL %s: take=%b expected %b", tag, take, e_take);
        end
        e.ap = e_ap; e.apc = e_apc; e.mp = e_mp; e.mpc = e_mpc; e.err = e_err; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) check_outs(q.pop_front());
        end
    end

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        slot_t A0, A1, B0, B1, C0, C1, D0, D1, E0, E1, F0, F1, G0, G1;
        slot_t H0, H1, I0, I1, P1, N1;
        exp_t r;
        b0 = BUB; b1 = BUB;
        repeat (3) @(negedge clk);
        r.ap = BUB; r.mp = BUB; r.apc = '0; r.mpc = '0; r.err = 1'b0; r.tag = "R1 reset";
        check_outs(r);
        rst = 1'b0;
        @(posedge clk); #5;
        r.tag = "R1 after reset";
        check_outs(r);

        step(0, 0, BUB, BUB, 0, BUB, 0, BUB, 0, 0, "R9 idle");

        A0 = mk(OP_ALU, 1, 2, 3, 32'hA0); A1 = mk(OP_LD, 4, 5, 31, 32'hA1);
        step(1, 32'h100, A0, A1, 1, A0, 32'h100, A1, 32'h104, 0, "R2 independent");

        B0 = mk(OP_ALU, 6, 4, 7, 32'hB0); B1 = mk(OP_ST, 31, 8, 9, 32'hB1);
        step(1, 32'h108, B0, B1, 0, BUB, 0, BUB, 0, 0, "R6 load-use lower slot stall");
        step(1, 32'h108, B0, B1, 1, B0, 32'h108, B1, 32'h10C, 0, "R6 reissue");

        C0 = mk(OP_ALU, 8, 1, 2, 32'hC0); C1 = mk(OP_ST, 31, 9, 8, 32'hC1);
        step(1, 32'h110, C0, C1, 0, C0, 32'h110, BUB, 0, 0, "R5 split store data head");
        step(1, 32'h110, C0, C1, 1, BUB, 0, C1, 32'h114, 0, "R5 split store data tail");

        D0 = mk(OP_ALU, 10, 1, 2, 32'hD0); D1 = mk(OP_LD, 11, 10, 31, 32'hD1);
        step(1, 32'h118, D0, D1, 0, D0, 32'h118, BUB, 0, 0, "R5 split base head");
        step(1, 32'h118, D0, D1, 1, BUB, 0, D1, 32'h11C, 0, "R5 split base tail");

        E0 = mk(OP_ALU, 31, 1, 2, 32'hE0); E1 = mk(OP_LD, 31, 31, 31, 32'hE1);
        step(1, 32'h120, E0, E1, 1, E0, 32'h120, E1, 32'h124, 0, "R7 r31 no split");

        F0 = mk(OP_ALU, 12, 31, 31, 32'hF0); F1 = mk(OP_NOP, 31, 31, 31, 32'h0);
        step(1, 32'h128, F0, F1, 1, F0, 32'h128, F1, 32'h12C, 0, "R7 r31 no load-use");

        G0 = mk(OP_ALU, 13, 1, 2, 32'h60); G1 = mk(OP_LD, 14, 2, 13, 32'h61);
        step(1, 32'h130, G0, G1, 1, G0, 32'h130, G1, 32'h134, 0, "R8 load src2 ignored");

        H0 = mk(OP_BR, 14, 1, 2, 32'h70); H1 = mk(OP_ST, 14, 3, 4, 32'h71);
        step(1, 32'h138, H0, H1, 1, H0, 32'h138, H1, 32'h13C, 0, "R8 rd field not a source");

        I0 = mk(OP_BR, 16, 3, 4, 32'h80); I1 = mk(OP_LD, 17, 16, 31, 32'h81);
        step(1, 32'h140, I0, I1, 1, I0, 32'h140, I1, 32'h144, 0, "R8 branch writes nothing");

        step(1, 32'h148, mk(OP_LD, 1, 17, 31, 32'h90), mk(OP_LD, 2, 3, 31, 32'h91),
             1, BUB, 0, BUB, 0, 1, "R3 R10 load in lower slot, error beats stall");
        step(1, 32'h150, mk(OP_ALU, 1, 2, 3, 32'h92), mk(OP_ALU, 4, 5, 6, 32'h93),
             1, BUB, 0, BUB, 0, 1, "R3 ALU in upper slot");
        step(1, 32'h158, mk(op_cls_e'(3'd7), 1, 2, 3, 32'h94), BUB,
             1, BUB, 0, BUB, 0, 1, "R3 class 7");
        step(1, 32'h15C, mk(OP_ALU, 1, 2, 3, 32'h95), mk(OP_LD, 5, 6, 31, 32'h96),
             1, BUB, 0, BUB, 0, 1, "R4 misaligned");

        P1 = mk(OP_LD, 21, 1, 31, 32'hA5);
        step(1, 32'h160, BUB, P1, 1, BUB, 32'h160, P1, 32'h164, 0, "R2 no-op lower slot");

        N1 = mk(OP_ST, 31, 21, 3, 32'hA6);
        step(1, 32'h168, BUB, N1, 0, BUB, 0, BUB, 0, 0, "R6 load-use upper slot stall");
        step(1, 32'h168, BUB, N1, 1, BUB, 32'h168, N1, 32'h16C, 0, "R6 upper slot reissue");

        step(0, 0, BUB, BUB, 0, BUB, 0, BUB, 0, 0, "R9 idle end");
        step(0, 0, BUB, BUB, 0, BUB, 0, BUB, 0, 0, "R9 idle drain");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule